// File: doc/BRIEF.md
# Fast Search Candidate Address Sequencer

This block walks through the full candidate schedule of a hexagon-based integer motion search for one 16x16 current macroblock. It issues one candidate per clock. Each candidate is the signed top-left coordinate of a 16x16 block, relative to the co-located position in a search window of ±16 pixels. The comparison logic downstream computes the matching cost of each candidate. After each pass it returns the best vector of that pass with a one-cycle pulse, and the sequencer then goes on to the next pass.

The schedule never ends early. It runs 16 passes:

| Pass | Content |
|------|---------|
| 0 | Centre candidate (0,0) |
| 1 to 4 | Four cross arms |
| 5 | Six-point hexagon |
| 6 to 13 | Eight half-rings of a big sixteen-point hexagon, scaled 1 to 4 |
| 14 | Second six-point hexagon |
| 15 | Four-point diamond |

The cross arms and the centre are anchored at the zero vector. Passes 5 to 15 are anchored on the best vector returned after the previous pass. Every candidate slot is issued. A slot that lands outside ±16 is flagged as not valid so that the cost logic skips it. The coordinate is not clipped. One full search takes 113 slots.

Top module: `fs_cand_seq`

## Requirements
- R1: While reset is held and after it is released, `slot_vld` and `done` are low until `start` is seen.
- R2: In the cycle after `start` is accepted while idle, the block issues one slot with `pass_idx`=0 at coordinate (0,0), flagged valid.
- R3: Passes 1 to 4 each issue 8 slots in consecutive cycles, anchored at (0,0). Candidate k (k=1..8) is at k times a unit step: (-2,0) for pass 1, (+2,0) for pass 2, (0,-2) for pass 3 and (0,+2) for pass 4. Negative y is upward.
- R4: After the last slot of each pass 0 to 14, no slot is issued until a `best_vld` pulse arrives. The first slot of the next pass appears in the cycle after that pulse, and each pass runs without gaps.
- R5: Passes 5 and 14 issue 6 slots around the anchor, in the order (-2,0), (-1,-2), (1,-2), (2,0), (1,2), (-1,2).
- R6: Passes 6 to 13 issue 8 slots each. Let m = pass-6. The scale is m/2+1 (integer division). For even m, the slot offsets are the scale times (-4,-2), (-4,-1), (-4,0), (-4,1), (-4,2), (-2,-3), (-2,3), (0,-4), in that order. For odd m, each offset is the negation of the even-m offset, in the same order.
- R7: Pass 15 issues 4 slots in the order (0,-1), (1,0), (0,1), (-1,0).
- R8: The anchor for passes 5 to 15 is the `best_x`/`best_y` captured with the `best_vld` pulse that ended the previous pass. `cand_vld` is high on a slot exactly when both coordinates lie within -16..16, and out-of-range coordinates are presented unclipped.
- R9: `done` pulses high for exactly one cycle, in the cycle after the last slot of pass 15, and the block is then idle.
- R10: `start` while a search is active and `best_vld` while a pass is still issuing slots have no effect on the slots that follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new search when idle |
| best_vld | input | 1 | One-cycle pulse: best vector of the finished pass is on `best_x`/`best_y` |
| best_x | input | 6 | Signed horizontal best vector, within ±16 |
| best_y | input | 6 | Signed vertical best vector, within ±16 |
| slot_vld | output | 1 | A candidate slot is presented this cycle |
| cand_vld | output | 1 | The presented candidate lies inside ±16 |
| cand_x | output | 8 | Signed horizontal candidate coordinate |
| cand_y | output | 8 | Signed vertical candidate coordinate |
| pass_idx | output | 4 | Pass number of the presented slot, 0 to 15 |
| done | output | 1 | One-cycle pulse after the final slot of pass 15 |

## Verification
The embedded properties take three things for granted about the inputs:
- `best_vld` is a single-cycle pulse.
- The returned vector lies within ±16, so every anchor plus offset fits the 8-bit coordinate.
- `rst_n` is held for at least one clock.

The stimulus always returns vectors inside that range, including ones on the edge, so that big-hexagon and hexagon slots fall outside the window. It also varies the delay before each pulse. It injects stray `start` and `best_vld` pulses only while slots are being issued, which is a legal case the block must ignore.

// File: rtl/fs_cand_seq.sv
module fs_cand_seq (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              best_vld,
  input  logic signed [5:0] best_x,
  input  logic signed [5:0] best_y,
  output logic              slot_vld,
  output logic              cand_vld,
  output logic signed [7:0] cand_x,
  output logic signed [7:0] cand_y,
  output logic [3:0]        pass_idx,
  output logic              done
);
  localparam logic signed [7:0] LIM = 8'sd16;
  localparam logic [3:0] LAST_PASS = 4'd15;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_HOLD} st_t;

  st_t              st;
  logic [3:0]       pass_q;
  logic [2:0]       pt;
  logic signed [5:0] ax_q, ay_q;
  logic [3:0]       npts;
  logic [4:0]       idx;
  logic [3:0]       scl;
  logic             neg;
  logic [2:0]       ring;
  logic [11:0]      ent;
  logic signed [7:0] ux, uy, sc, px, py, ox, oy;
  logic             last_pt;

  function automatic logic [11:0] pk(input logic signed [5:0] x, input logic signed [5:0] y);
    pk = {x, y};
  endfunction

  function automatic logic [11:0] rom(input logic [4:0] i);
    case (i)
      5'd0:  rom = pk(-6'sd4, -6'sd2);
      5'd1:  rom = pk(-6'sd4, -6'sd1);
      5'd2:  rom = pk(-6'sd4,  6'sd0);
      5'd3:  rom = pk(-6'sd4,  6'sd1);
      5'd4:  rom = pk(-6'sd4,  6'sd2);
      5'd5:  rom = pk(-6'sd2, -6'sd3);
      5'd6:  rom = pk(-6'sd2,  6'sd3);
      5'd7:  rom = pk( 6'sd0, -6'sd4);
      5'd8:  rom = pk(-6'sd2,  6'sd0);
      5'd9:  rom = pk(-6'sd1, -6'sd2);
      5'd10: rom = pk( 6'sd1, -6'sd2);
      5'd11: rom = pk( 6'sd2,  6'sd0);
      5'd12: rom = pk( 6'sd1,  6'sd2);
      5'd13: rom = pk(-6'sd1,  6'sd2);
      5'd14: rom = pk( 6'sd0, -6'sd1);
      5'd15: rom = pk( 6'sd1,  6'sd0);
      5'd16: rom = pk( 6'sd0,  6'sd1);
      5'd17: rom = pk(-6'sd1,  6'sd0);
      5'd18: rom = pk(-6'sd2,  6'sd0);
      5'd19: rom = pk( 6'sd2,  6'sd0);
      5'd20: rom = pk( 6'sd0, -6'sd2);
      5'd21: rom = pk( 6'sd0,  6'sd2);
      default: rom = '0;
    endcase
  endfunction

  always_comb begin
    idx  = '0;
    scl  = 4'd1;
    neg  = 1'b0;
    npts = 4'd8;
    ring = 3'(pass_q - 4'd6);
    if (pass_q == 4'd0) begin
      npts = 4'd1;
      scl  = 4'd0;
    end else if (pass_q <= 4'd4) begin
      idx = 5'd17 + {1'b0, pass_q};
      scl = {1'b0, pt} + 4'd1;
    end else if (pass_q == 4'd5 || pass_q == 4'd14) begin
      npts = 4'd6;
      idx  = 5'd8 + {2'b0, pt};
    end else if (pass_q == LAST_PASS) begin
      npts = 4'd4;
      idx  = 5'd14 + {2'b0, pt};
    end else begin
      idx = {2'b0, pt};
      scl = {2'b0, ring[2:1]} + 4'd1;
      neg = ring[0];
    end
  end

  assign ent = rom(idx);
  assign ux  = {{2{ent[11]}}, ent[11:6]};
  assign uy  = {{2{ent[5]}},  ent[5:0]};
  assign sc  = {4'b0, scl};
  assign px  = ux * sc;
  assign py  = uy * sc;
  assign ox  = neg ? -px : px;
  assign oy  = neg ? -py : py;

  assign cand_x   = {{2{ax_q[5]}}, ax_q} + ox;
  assign cand_y   = {{2{ay_q[5]}}, ay_q} + oy;
  assign slot_vld = (st == S_RUN);
  assign cand_vld = slot_vld && (cand_x >= -LIM) && (cand_x <= LIM)
                             && (cand_y >= -LIM) && (cand_y <= LIM);
  assign pass_idx = pass_q;
  assign last_pt  = ({1'b0, pt} == npts - 4'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      pass_q <= '0;
      pt     <= '0;
      ax_q   <= '0;
      ay_q   <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st     <= S_RUN;
          pass_q <= '0;
          pt     <= '0;
          ax_q   <= '0;
          ay_q   <= '0;
        end
        S_RUN: begin
          if (last_pt) begin
            pt <= '0;
            if (pass_q == LAST_PASS) begin
              st   <= S_IDLE;
              done <= 1'b1;
            end else begin
              st <= S_HOLD;
            end
          end else begin
            pt <= pt + 3'd1;
          end
        end
        S_HOLD: if (best_vld) begin
          st     <= S_RUN;
          pass_q <= pass_q + 4'd1;
          if (pass_q >= 4'd4) begin
            ax_q <= best_x;
            ay_q <= best_y;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_centre_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start) |=> (slot_vld && pass_idx == 4'd0 && cand_x == 8'sd0 && cand_y == 8'sd0));

  p_hold_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD && !best_vld) |=> !slot_vld);

  p_pass_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_vld && $past(slot_vld)) |-> (pass_idx == $past(pass_idx)));

  p_cross_inside_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_vld && pass_idx <= 4'd4) |-> cand_vld);

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !slot_vld));

  p_done_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(slot_vld) && $past(pass_idx) == LAST_PASS));
endmodule

// File: tb/fs_cand_seq_tb.sv
`timescale 1ns/1ps
module fs_cand_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic best_vld = 1'b0;
  logic signed [5:0] best_x = '0, best_y = '0;
  logic slot_vld, cand_vld, done;
  logic signed [7:0] cand_x, cand_y;
  logic [3:0] pass_idx;

  int errs = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  fs_cand_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .best_vld(best_vld),
    .best_x(best_x), .best_y(best_y), .slot_vld(slot_vld), .cand_vld(cand_vld),
    .cand_x(cand_x), .cand_y(cand_y), .pass_idx(pass_idx), .done(done));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int npts(input int p);
    if (p == 0) return 1;
    if (p <= 4) return 8;
    if (p == 5 || p == 14) return 6;
    if (p == 15) return 4;
    return 8;
  endfunction

  function automatic string tag(input int p);
    if (p == 0) return "R2";
    if (p <= 4) return "R3";
    if (p == 5 || p == 14) return "R5";
    if (p == 15) return "R7";
    return "R6";
  endfunction

  function automatic void offs(input int p, input int k, output int dx, output int dy);
    int cdx[4] = '{-2, 2, 0, 0};
    int cdy[4] = '{0, 0, -2, 2};
    int hx[6]  = '{-2, -1, 1, 2, 1, -1};
    int hy[6]  = '{0, -2, -2, 0, 2, 2};
    int gx[8]  = '{-4, -4, -4, -4, -4, -2, -2, 0};
    int gy[8]  = '{-2, -1, 0, 1, 2, -3, 3, -4};
    int qx[4]  = '{0, 1, 0, -1};
    int qy[4]  = '{-1, 0, 1, 0};
    int m, s;
    if (p == 0) begin dx = 0; dy = 0; end
    else if (p <= 4) begin dx = cdx[p-1] * (k + 1); dy = cdy[p-1] * (k + 1); end
    else if (p == 5 || p == 14) begin dx = hx[k]; dy = hy[k]; end
    else if (p == 15) begin dx = qx[k]; dy = qy[k]; end
    else begin
      m = p - 6;
      s = (m % 2 == 1) ? -1 : 1;
      dx = s * (m / 2 + 1) * gx[k];
      dy = s * (m / 2 + 1) * gy[k];
    end
  endfunction

  function automatic void pick(input int run, input int p, output int x, output int y);
    if (run == 0) begin
      x = ((p * 3) % 9) - 4;
      y = 4 - ((p * 5) % 9);
    end else if (p % 2 == 1) begin
      x = 16; y = -16;
    end else begin
      x = -15; y = 13;
    end
  endfunction

  task automatic run_search(input int run);
    int dx, dy, ex, ey, bx, by, lbx, lby, inr;
    lbx = 0; lby = 0;
    @(negedge clk);
    start = 1'b1;
    for (int p = 0; p < 16; p++) begin
      for (int k = 0; k < npts(p); k++) begin
        @(negedge clk);
        start = 1'b0;
        best_vld = 1'b0;
        offs(p, k, dx, dy);
        ex = ((p >= 5) ? lbx : 0) + dx;
        ey = ((p >= 5) ? lby : 0) + dy;
        inr = (ex >= -16 && ex <= 16 && ey >= -16 && ey <= 16) ? 1 : 0;
        chk(tag(p), int'(slot_vld), 1);
        chk(tag(p), int'(pass_idx), p);
        chk(tag(p), int'(cand_x), ex);
        chk(tag(p), int'(cand_y), ey);
        chk("R8", int'(cand_vld), inr);
        if (k == 2) begin
          // R10 stray pulses while slots are issuing
          best_vld = 1'b1;
          best_x = -6'sd9;
          best_y = 6'sd7;
          start = 1'b1;
        end
      end
      if (p < 15) begin
        pick(run, p, bx, by);
        for (int g = 0; g < 1 + (p % 3); g++) begin
          @(negedge clk);
          start = 1'b0;
          best_vld = 1'b0;
          chk("R4", int'(slot_vld), 0);
          chk("R4", int'(done), 0);
        end
        best_vld = 1'b1;
        best_x = 6'(bx);
        best_y = 6'(by);
        lbx = bx;
        lby = by;
      end
    end
    @(negedge clk);
    best_vld = 1'b0;
    chk("R9", int'(done), 1);
    chk("R9", int'(slot_vld), 0);
    @(negedge clk);
    chk("R9", int'(done), 0);
    chk("R9", int'(slot_vld), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL R9 watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) begin
      @(negedge clk);
      chk("R1", int'(slot_vld), 0);
      chk("R1", int'(done), 0);
    end
    rst_n = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk("R1", int'(slot_vld), 0);
      chk("R1", int'(done), 0);
    end
    run_search(0);
    repeat (4) begin
      @(negedge clk);
      chk("R9", int'(slot_vld), 0);
    end
    run_search(1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule